// File: doc/BRIEF.md
# Triple-Copy Voted Memory with Background Scrubber

This block is a small random-access memory that keeps every word in three identical copies. A user write stores the word in all three copies. A user read returns the bitwise majority of the three copies one cycle later, so a bit flipped in any one copy never reaches the reader.

Corrupted bits would otherwise stay in the arrays until the user wrote that word again. A background scrubber walks the address space on its own, using a second port on each copy. At each address it spends one cycle reading the three copies and one cycle writing the voted word back into all three, then moves to the next address and wraps after the last one. A one-cycle flag reports every scrub read that found the copies in disagreement. User traffic always takes precedence: a user write to the address being scrubbed cancels that write-back.

Top module: `tmr_scrub_mem`

## Requirements
- R1: After reset is released, `rdata` and `mismatch` are 0 and the scrubber begins at address 0. If the copies at address 0 disagree, `mismatch` is high in the second cycle after release.
- R2: When `we` is high at a clock edge, `wdata` is stored at `addr` in all three copies. A read returns its word in the cycle after the edge that sampled `addr`. A read and a write to the same address at the same edge return the previous contents.
- R3: `rdata` is the bitwise majority of the three copies. Any corruption confined to one copy is therefore invisible at `rdata`.
- R4: Each scrub step takes two cycles, a read cycle and then a write-back cycle at the same address. The address then advances by one and wraps from DEPTH-1 to 0, so a given address is visited every 2*DEPTH cycles.
- R5: The write-back stores the voted word into all three copies. A single-copy error is removed, so a later error in a different copy at that address is also masked.
- R6: `mismatch` is high for exactly one cycle, right after the write-back cycle of a scrub step whose read found the three copies differing. It is low at all other times.
- R7: A user write to the address under scrub, in either cycle of the step, cancels that step's write-back, and the user's data is kept. The scrubber never writes an address in the same cycle as the user port.
- R8: If two copies carry the same wrong bits, the vote returns the wrong word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | User address for reads and writes |
| we | input | 1 | User write enable |
| wdata | input | DATA_W | User write data |
| rdata | output | DATA_W | Voted read data, one cycle after the address |
| mismatch | output | 1 | One-cycle pulse when a scrub read found the copies differing |

## Verification
The assertions assume that `addr` stays below DEPTH and that the user port and scrubber never write one location in the same cycle; the latter is enforced by the design and checked at each copy. The stimulus keeps user addresses in range. It flips bits inside individual copies only at falling edges, so each flip falls wholly on one side of a scrub read. The reference model holds its own three copies and its own scrub position. The bench aims collision writes at the address that model says is being scrubbed, in both the read and the write-back cycle.

// File: rtl/tmr_mem_pkg.sv
package tmr_mem_pkg;

    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } scrub_phase_e;

    function automatic logic maj_bit(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

endpackage

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int W  = 16,
    parameter int D  = 64,
    parameter int AW = $clog2(D)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [W-1:0]  a_wdata,
    output logic [W-1:0]  a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [W-1:0]  b_wdata,
    output logic [W-1:0]  b_rdata
);

    typedef struct packed {
        logic [W-1:0] a_rd;
        logic [W-1:0] b_rd;
    } rd_regs_t;

    logic [W-1:0] mem_q [D];
    rd_regs_t     r_d, r_q;

    always_ff @(posedge clk) begin
        if (a_we) mem_q[a_addr] <= a_wdata;
        if (b_we) mem_q[b_addr] <= b_wdata;
    end

    always_comb begin
        r_d      = r_q;
        r_d.a_rd = mem_q[a_addr];
        r_d.b_rd = mem_q[b_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign a_rdata = r_q.a_rd;
    assign b_rdata = r_q.b_rd;

    // R7
    port_collision_chk: assert property (@(posedge clk) disable iff (rst)
        !(a_we && b_we && (a_addr == b_addr)));

endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int W = 16
) (
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    input  logic [W-1:0] in2,
    output logic [W-1:0] voted,
    output logic         disagree
);
    import tmr_mem_pkg::*;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign voted[b] = maj_bit(in0[b], in1[b], in2[b]);
    end

    assign disagree = |((in0 ^ in1) | (in0 ^ in2));

endmodule

// File: rtl/tmr_scrub_seq.sv
module tmr_scrub_seq #(
    parameter int D  = 64,
    parameter int AW = $clog2(D)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          user_we,
    input  logic [AW-1:0] user_addr,
    input  logic          rb_disagree,
    output logic [AW-1:0] scan_addr,
    output logic          wb_en,
    output logic          flag
);
    import tmr_mem_pkg::*;

    localparam logic [AW-1:0] LAST_A = AW'(D - 1);

    typedef struct packed {
        scrub_phase_e  phase;
        logic [AW-1:0] addr;
        logic          skip;
        logic          flag;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       hit;

    always_comb begin
        s_d      = s_q;
        s_d.flag = 1'b0;
        hit      = user_we && (user_addr == s_q.addr);
        wb_en    = 1'b0;
        if (s_q.phase == PH_READ) begin
            s_d.skip  = hit;
            s_d.phase = PH_WRITE;
        end else begin
            wb_en     = !s_q.skip && !hit;
            s_d.flag  = rb_disagree;
            s_d.skip  = 1'b0;
            s_d.phase = PH_READ;
            s_d.addr  = (s_q.addr == LAST_A) ? '0 : s_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{phase: PH_READ, addr: '0, skip: 1'b0, flag: 1'b0};
        else     s_q <= s_d;
    end

    assign scan_addr = s_q.addr;
    assign flag      = s_q.flag;

    // R4
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_READ) |=> (s_q.phase == PH_WRITE));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_READ) |=> $stable(s_q.addr));

    // R4
    addr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_WRITE) |=>
            (s_q.addr == (($past(s_q.addr) == LAST_A) ? '0 : $past(s_q.addr) + 1'b1)));

    // R6
    flag_origin_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.flag |-> $past(s_q.phase == PH_WRITE));

    // R6
    flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.flag |=> !s_q.flag);

endmodule

// File: rtl/tmr_scrub_mem.sv
module tmr_scrub_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              mismatch
);

    localparam int COPIES = 3;

    logic [DATA_W-1:0] a_rd [COPIES];
    logic [DATA_W-1:0] b_rd [COPIES];
    logic [DATA_W-1:0] scrub_word;
    logic              scrub_dis;
    logic              user_dis;
    logic [ADDR_W-1:0] scan_addr;
    logic              wb_en;

    for (genvar k = 0; k < COPIES; k++) begin : g_copy
        tmr_bank #(.W(DATA_W), .D(DEPTH), .AW(ADDR_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .a_addr  (addr),
            .a_we    (we),
            .a_wdata (wdata),
            .a_rdata (a_rd[k]),
            .b_addr  (scan_addr),
            .b_we    (wb_en),
            .b_wdata (scrub_word),
            .b_rdata (b_rd[k])
        );
    end

    tmr_voter #(.W(DATA_W)) u_user_vote (
        .in0      (a_rd[0]),
        .in1      (a_rd[1]),
        .in2      (a_rd[2]),
        .voted    (rdata),
        .disagree (user_dis)
    );

    tmr_voter #(.W(DATA_W)) u_scrub_vote (
        .in0      (b_rd[0]),
        .in1      (b_rd[1]),
        .in2      (b_rd[2]),
        .voted    (scrub_word),
        .disagree (scrub_dis)
    );

    tmr_scrub_seq #(.D(DEPTH), .AW(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .user_we     (we),
        .user_addr   (addr),
        .rb_disagree (scrub_dis),
        .scan_addr   (scan_addr),
        .wb_en       (wb_en),
        .flag        (mismatch)
    );

    // R3
    agree_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !user_dis |-> (rdata == a_rd[1]));

    // R7
    wb_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (addr == scan_addr)) |-> !wb_en);

endmodule

// File: tb/tb_tmr_scrub_mem.sv
module tb_tmr_scrub_mem;
    localparam int W     = 8;
    localparam int D     = 16;
    localparam int AW    = 4;
    localparam int SWEEP = 2 * D;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          mismatch;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int cyc = 0;
    int last_pulse = 0;
    bit done = 0;

    // reference model: three copies, scrub position, phase (0 read, 1 write-back)
    logic [W-1:0] m [3][D];
    logic [W-1:0] snap [3];
    logic [W-1:0] golden [D];
    int  m_idx = 0;
    int  m_ph = 0;
    bit  m_skip = 0;
    logic [W-1:0] exp_rd = '0;
    bit  exp_flag = 0;

    tmr_scrub_mem #(.DATA_W(W), .DEPTH(D)) dut (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
        .rdata(rdata), .mismatch(mismatch)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] vote(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic [W-1:0] z);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) r[b] = (x[b] + y[b] + z[b]) >= 2;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_idx = 0; m_ph = 0; m_skip = 0; exp_rd = '0; exp_flag = 0;
        end else begin
            logic [W-1:0] nrd;
            bit hit;
            nrd = vote(m[0][addr], m[1][addr], m[2][addr]);
            hit = we && (int'(addr) == m_idx);
            if (m_ph == 0) begin
                for (int k = 0; k < 3; k++) snap[k] = m[k][m_idx];
                m_skip = hit;
                exp_flag = 0;
                m_ph = 1;
            end else begin
                exp_flag = (snap[0] != snap[1]) || (snap[0] != snap[2]);
                if (!m_skip && !hit)
                    for (int k = 0; k < 3; k++) m[k][m_idx] = vote(snap[0], snap[1], snap[2]);
                m_ph = 0;
                m_idx = (m_idx == D - 1) ? 0 : m_idx + 1;
            end
            if (we) for (int k = 0; k < 3; k++) m[k][addr] = wdata;
            exp_rd = nrd;
        end
    end

    // lockstep comparison every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc++;
            total++;
            if (rdata !== exp_rd) begin
                bad++;
                $display("FAIL R3 lockstep rdata cyc=%0d actual=%h expected=%h", cyc, rdata, exp_rd);
            end
            total++;
            if (mismatch !== exp_flag) begin
                bad++;
                $display("FAIL R6 lockstep mismatch (R4 timing) cyc=%0d actual=%0b expected=%0b",
                         cyc, mismatch, exp_flag);
            end
            if (mismatch === 1'b1) begin
                pulses++;
                last_pulse = cyc;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic inject(input int k, input int a, input logic [W-1:0] mask);
        case (k)
            0: dut.g_copy[0].u_bank.mem_q[a] = dut.g_copy[0].u_bank.mem_q[a] ^ mask;
            1: dut.g_copy[1].u_bank.mem_q[a] = dut.g_copy[1].u_bank.mem_q[a] ^ mask;
            default: dut.g_copy[2].u_bank.mem_q[a] = dut.g_copy[2].u_bank.mem_q[a] ^ mask;
        endcase
        m[k][a] = m[k][a] ^ mask;
    endtask

    task automatic wr(input int a, input logic [W-1:0] v);
        @(negedge clk);
        addr = AW'(a); wdata = v; we = 1'b1;
        golden[a] = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [W-1:0] ev, input string req);
        @(negedge clk);
        addr = AW'(a); we = 1'b0;
        @(negedge clk);
        check(rdata === ev, req, int'(rdata), int'(ev));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < D; a++) begin
            golden[a] = '0;
            for (int k = 0; k < 3; k++) inject(k, a, dut.g_copy[0].u_bank.mem_q[a] ^ dut.g_copy[0].u_bank.mem_q[a]);
        end
        for (int a = 0; a < D; a++) begin
            dut.g_copy[0].u_bank.mem_q[a] = '0;
            dut.g_copy[1].u_bank.mem_q[a] = '0;
            dut.g_copy[2].u_bank.mem_q[a] = '0;
            for (int k = 0; k < 3; k++) m[k][a] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and scrub starting at address 0
        check(rdata === '0, "R1 rdata after reset", int'(rdata), 0);
        check(mismatch === 1'b0, "R1 mismatch after reset", int'(mismatch), 0);
        inject(0, 0, 8'h01);
        @(negedge clk);
        @(negedge clk);
        check(mismatch === 1'b1, "R1 first scrub at address 0", int'(mismatch), 1);

        // R2: fill and read back
        for (int a = 0; a < D; a++) wr(a, W'(8'h30 + a * 7));
        for (int a = 0; a < D; a++) rd_chk(a, golden[a], "R2 readback");

        // R2: read and write at the same edge return the old word
        @(negedge clk);
        addr = 4'd2; wdata = 8'hA5; we = 1'b1;
        begin
            logic [W-1:0] old2;
            old2 = golden[2];
            golden[2] = 8'hA5;
            @(negedge clk);
            we = 1'b0;
            check(rdata === old2, "R2 read-during-write old data", int'(rdata), int'(old2));
        end
        rd_chk(2, 8'hA5, "R2 new data after write");

        // R3: single-copy corruption masked
        @(negedge clk);
        inject(1, 5, 8'hFF);
        rd_chk(5, golden[5], "R3 masked single-copy error");
        idle(SWEEP + 4);

        // R6: exactly one pulse per disagreeing address per sweep
        @(negedge clk);
        pulses = 0;
        inject(2, 9, 8'h0F);
        idle(SWEEP + 4);
        check(pulses == 1, "R6 one pulse for one bad address", pulses, 1);
        pulses = 0;
        idle(SWEEP + 4);
        // R5: repaired, so no further pulses
        check(pulses == 0, "R5 no pulse after repair", pulses, 0);
        @(negedge clk);
        inject(0, 9, 8'hF0);
        rd_chk(9, golden[9], "R5 second copy error masked after repair");
        idle(SWEEP + 4);

        // R4: revisit period of one address
        begin
            int p0, t1, t2, guard;
            @(negedge clk);
            p0 = pulses;
            inject(1, 4, 8'h80);
            guard = 0;
            while (pulses == p0 && guard < 4 * SWEEP) begin @(negedge clk); guard++; end
            t1 = last_pulse;
            p0 = pulses;
            inject(1, 4, 8'h40);
            guard = 0;
            while (pulses == p0 && guard < 4 * SWEEP) begin @(negedge clk); guard++; end
            t2 = last_pulse;
            check((t2 - t1) == SWEEP, "R4 revisit period", t2 - t1, SWEEP);
        end
        idle(SWEEP + 4);

        // R8: two identical wrong copies outvote the good one
        @(negedge clk);
        inject(0, 11, 8'h3C);
        inject(1, 11, 8'h3C);
        golden[11] = golden[11] ^ 8'h3C;
        rd_chk(11, golden[11], "R8 double error wins vote");

        // R7: user write into the address under scrub, both phases
        for (int rep = 0; rep < 4; rep++) begin
            int tgt;
            logic [W-1:0] v;
            @(negedge clk);
            while (m_ph != (rep % 2)) @(negedge clk);
            tgt = m_idx;
            v = W'(8'h51 + rep * 19);
            addr = AW'(tgt); wdata = v; we = 1'b1;
            golden[tgt] = v;
            @(negedge clk);
            we = 1'b0;
            idle(2);
            rd_chk(tgt, v, "R7 user write survives scrub collision");
        end
        idle(SWEEP + 4);
        for (int a = 0; a < D; a++) rd_chk(a, golden[a], "R7 final contents");

        done = 1;
        summary();
        $finish;
    end
endmodule